// File: doc/BRIEF.md
# USB Device Interrupt Flag Bank

This block holds the interrupt status flags of a USB device controller and presents them to a CPU through a small byte-wide register port. The USB protocol engine signals each event with a single-cycle pulse. Those events are:

- an IN token for the endpoint while the transmit buffer holds nothing valid;
- an IN packet that the host acknowledged;
- a resume or bus reset seen while suspended;
- a suspend condition.

The bus-power sense input is different: it is a level. It is synchronised inside the block, and any change of it counts as a connect or disconnect event.

Each flag is paired with an enable bit. The block drives one registered interrupt line that is high while any enabled flag is set. Software clears a flag by writing 0 to its bit. Writing 1 leaves the flag as it is, so a read-modify-write never loses an event that arrived in between. The second flag register also carries a live "configuration valid" status bit. That bit follows its input and cannot be written.

Top module: `usb_irq_flags`

## Requirements
- R1: After reset, the first flag register (address 0) and both enable registers read 0, and `irq` is 0. The second flag register (address 1) reads 0x20 while `cfg_valid` is 1.
- R2: The first flag register sets its bits on these events. Bit 2 sets on a pulse of `ev_in_nodata`. Bit 1 sets on a pulse of `ev_in_acked`. Each bit reads back as 1 on the next read.
- R3: A write to a flag register clears every flag whose write-data bit is 0. Every flag whose write-data bit is 1 keeps its value.
- R4: If an event and a write-0 to the same flag fall in the same cycle, the flag ends up set.
- R5: Bit 0 of address 0 sets on every rising or falling change of `vbus_sense`. The input passes through a two-flop synchroniser, so the flag is set three clock edges after the input changes.
- R6: Bit 3 of address 1 sets on `ev_wake`, and bit 2 of address 1 sets on `ev_suspend`. Both set only while `susp_ctrl` is 1; otherwise those events are ignored.
- R7: Bit 5 of address 1 reads the `cfg_valid` input, and writes to that bit have no effect.
- R8: The enable registers mirror the flag bit positions: address 2 enables address 0, and address 3 enables address 1. `irq` is a register that goes high one edge after any flag and its enable are both 1. It falls one edge after the last such pair stops being both 1.
- R9: These bits always read 0: unused bits of the flag and enable registers, and every bit at addresses 4 to 7. Writes to those bits are dropped. Enable address 2 keeps bits 2:0, and enable address 3 keeps bits 5, 3 and 2.
- R10: Read data is registered: `rdata` shows the register selected by `addr` one clock edge after `addr` is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | 3 | Register select |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| ev_in_nodata | input | 1 | Pulse: IN token with no valid transmit data |
| ev_in_acked | input | 1 | Pulse: IN packet acknowledged by host |
| vbus_sense | input | 1 | Asynchronous bus-power sense level |
| ev_wake | input | 1 | Pulse: resume or bus reset detected |
| ev_suspend | input | 1 | Pulse: suspend condition detected |
| susp_ctrl | input | 1 | Suspend-mode control, qualifies wake and suspend flags |
| cfg_valid | input | 1 | Live configuration-valid status |
| irq | output | 1 | Interrupt request to CPU |

## Verification
Assertions check several behaviours on every cycle:
- a write-0 with no event clears the flag, and a write-1 leaves it unchanged;
- a pulse always leaves its flag set;
- wake and suspend flags never rise while `susp_ctrl` is 0;
- `irq` follows the enabled flags one edge later;
- the unused read bits stay at 0.

Only the bench's scenarios can show the behaviours seen through the port. These are the synchroniser delay on the bus-power sense, the live `cfg_valid` view, the one-cycle read latency, and the full cross of flag patterns against enable masks.

// File: rtl/usb_irq_flags.sv
module usb_irq_flags #(
  parameter int AW = 3,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] addr,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          ev_in_nodata,
  input  logic          ev_in_acked,
  input  logic          vbus_sense,
  input  logic          ev_wake,
  input  logic          ev_suspend,
  input  logic          susp_ctrl,
  input  logic          cfg_valid,
  output logic          irq
);

  localparam logic [AW-1:0] A_FLAG0 = AW'(0);
  localparam logic [AW-1:0] A_FLAG1 = AW'(1);
  localparam logic [AW-1:0] A_EN0   = AW'(2);
  localparam logic [AW-1:0] A_EN1   = AW'(3);
  localparam logic [DW-1:0] M0      = DW'(8'h07);
  localparam logic [DW-1:0] M1_RW   = DW'(8'h0C);
  localparam logic [DW-1:0] M1_EN   = DW'(8'h2C);

  logic [DW-1:0] flag0_q, flag1_q, en0_q, en1_q;
  logic [2:0]    vb_q;
  logic          vb_edge;

  always_ff @(posedge clk) begin
    if (!rst_n) vb_q <= '0;
    else        vb_q <= {vb_q[1:0], vbus_sense};
  end
  assign vb_edge = vb_q[1] ^ vb_q[2];

  wire wr0 = wr_en && addr == A_FLAG0;
  wire wr1 = wr_en && addr == A_FLAG1;

  logic [DW-1:0] ev0, ev1, keep0, keep1, flag1_view;
  assign ev0   = DW'({ev_in_nodata, ev_in_acked, vb_edge});
  assign ev1   = DW'({susp_ctrl & ev_wake, susp_ctrl & ev_suspend, 2'b00});
  assign keep0 = wr0 ? wdata : '1;
  assign keep1 = wr1 ? wdata : '1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag0_q <= '0;
      flag1_q <= '0;
      en0_q   <= '0;
      en1_q   <= '0;
    end else begin
      flag0_q <= ((flag0_q & keep0) | ev0) & M0;
      flag1_q <= ((flag1_q & keep1) | ev1) & M1_RW;
      if (wr_en && addr == A_EN0) en0_q <= wdata & M0;
      if (wr_en && addr == A_EN1) en1_q <= wdata & M1_EN;
    end
  end

  assign flag1_view = flag1_q | (cfg_valid ? DW'(8'h20) : '0);

  logic any_en;
  assign any_en = |(flag0_q & en0_q) | |(flag1_view & en1_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq   <= 1'b0;
      rdata <= '0;
    end else begin
      irq <= any_en;
      unique case (addr)
        A_FLAG0: rdata <= flag0_q;
        A_FLAG1: rdata <= flag1_view;
        A_EN0:   rdata <= en0_q;
        A_EN1:   rdata <= en1_q;
        default: rdata <= '0;
      endcase
    end
  end

  assert_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && !wdata[1] && !ev_in_acked) |=> !flag0_q[1]);
  assert_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr0 && wdata[2]) |=> flag0_q[2] == $past(flag0_q[2] | ev_in_nodata));
  assert_event_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in_acked |=> flag0_q[1]);
  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ev_in_nodata |=> flag0_q[2]);
  assert_qualified_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!susp_ctrl && !flag1_q[3] && !flag1_q[2]) |=> (!flag1_q[3] && !flag1_q[2]));
  assert_irq_rise_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flag0_q & en0_q)) |=> irq);
  assert_irq_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!(|(flag0_q & en0_q)) && !(|(flag1_view & en1_q))) |=> !irq);
  assert_unused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rdata[7:6] == 2'b00);

endmodule

// File: tb/tb_usb_irq_flags.sv
module tb_usb_irq_flags;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic [2:0] addr = 0;
  logic wr_en = 0;
  logic [7:0] wdata = 0, rdata;
  logic ev_in_nodata = 0, ev_in_acked = 0, vbus_sense = 0;
  logic ev_wake = 0, ev_suspend = 0, susp_ctrl = 0, cfg_valid = 1;
  logic irq;
  int checks = 0, fails = 0;
  logic [7:0] d;

  always #(CLK_PERIOD/2) clk = ~clk;

  usb_irq_flags dut (.*);

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk) addr = a;
    @(negedge clk) v = rdata;
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] v);
    @(negedge clk) begin addr = a; wdata = v; wr_en = 1; end
    @(negedge clk) wr_en = 0;
  endtask

  task automatic set_flags0();
    @(negedge clk) begin ev_in_nodata = 1; ev_in_acked = 1; vbus_sense = ~vbus_sense; end
    @(negedge clk) begin ev_in_nodata = 0; ev_in_acked = 0; end
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 8'h00, 8'h01);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(0, d); chk("R1 flag0", d, 8'h00);
    rd(1, d); chk("R1 flag1", d, 8'h20);
    rd(2, d); chk("R1 en0", d, 8'h00);
    rd(3, d); chk("R1 en1", d, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    @(negedge clk) ev_in_nodata = 1;
    @(negedge clk) ev_in_nodata = 0;
    rd(0, d); chk("R2 xfer_req", d, 8'h04);
    @(negedge clk) ev_in_acked = 1;
    @(negedge clk) ev_in_acked = 0;
    rd(0, d); chk("R2 tx_done", d, 8'h06);
    wr(0, 8'h00);

    // R5: edge timing of the synchronised bus-power sense
    @(negedge clk) vbus_sense = 1;
    @(negedge clk); @(negedge clk);
    addr = 0;
    @(negedge clk) chk("R5 not yet", rdata, 8'h00);
    @(negedge clk) chk("R5 rise", rdata, 8'h01);
    wr(0, 8'h00);
    @(negedge clk) vbus_sense = 0;
    repeat (4) @(negedge clk);
    rd(0, d); chk("R5 fall", d, 8'h01);
    wr(0, 8'h00);

    // R3 sweep over clear patterns
    for (int p = 0; p < 8; p++) begin
      set_flags0();
      wr(0, 8'(p));
      rd(0, d); chk("R3 clear pattern", d, 8'(p) & 8'h07);
      wr(0, 8'h00);
    end

    // R4: clear and event in the same cycle
    @(negedge clk) begin addr = 0; wdata = 0; wr_en = 1; ev_in_acked = 1; end
    @(negedge clk) begin wr_en = 0; ev_in_acked = 0; end
    rd(0, d); chk("R4 event wins", d, 8'h02);
    wr(0, 8'h00);

    // R6: qualification by suspend control
    susp_ctrl = 0;
    @(negedge clk) begin ev_wake = 1; ev_suspend = 1; end
    @(negedge clk) begin ev_wake = 0; ev_suspend = 0; end
    rd(1, d); chk("R6 ignored", d, 8'h20);
    susp_ctrl = 1;
    for (int p = 0; p < 4; p++) begin
      @(negedge clk) begin ev_wake = 1; ev_suspend = 1; end
      @(negedge clk) begin ev_wake = 0; ev_suspend = 0; end
      rd(1, d); chk("R6 set", d, 8'h2C);
      wr(1, 8'(p << 2));
      rd(1, d); chk("R6 clear pattern", d, 8'h20 | (8'(p << 2) & 8'h0C));
      wr(1, 8'h00);
    end
    susp_ctrl = 0;

    // R7: live, non-writable status bit
    wr(1, 8'h00);
    rd(1, d); chk("R7 write ignored", d, 8'h20);
    cfg_valid = 0;
    rd(1, d); chk("R7 follows input", d, 8'h00);
    wr(1, 8'hFF);
    rd(1, d); chk("R7 set ignored", d, 8'h00);
    cfg_valid = 1;

    // R9
    wr(2, 8'hFF); rd(2, d); chk("R9 en0 mask", d, 8'h07);
    wr(3, 8'hFF); rd(3, d); chk("R9 en1 mask", d, 8'h2C);
    wr(5, 8'hFF); rd(5, d); chk("R9 unmapped", d, 8'h00);
    rd(7, d); chk("R9 unmapped 7", d, 8'h00);
    wr(2, 8'h00); wr(3, 8'h00);

    // R10: read latency
    rd(1, d);
    @(negedge clk) addr = 2;
    #1 chk("R10 old data held", rdata, 8'h20);
    @(negedge clk) chk("R10 new data", rdata, 8'h00);

    // R8 sweep: flags x enables
    for (int e = 0; e < 8; e++) begin
      for (int f = 0; f < 8; f++) begin
        set_flags0();
        wr(0, 8'(f));
        wr(2, 8'(e));
        @(negedge clk);
        chk("R8 irq sweep", {7'b0, irq}, {7'b0, |(e & f)});
        wr(2, 8'h00);
        wr(0, 8'h00);
      end
    end
    wr(3, 8'h20);
    @(negedge clk) chk("R8 cfg enable", {7'b0, irq}, 8'h01);
    wr(3, 8'h00);

    // R8 deassert timing
    set_flags0();
    wr(2, 8'h02);
    @(negedge clk) chk("R8 high", {7'b0, irq}, 8'h01);
    @(negedge clk) begin addr = 0; wdata = 8'h05; wr_en = 1; end
    @(negedge clk) begin wr_en = 0; chk("R8 one edge lag", {7'b0, irq}, 8'h01); end
    @(negedge clk) chk("R8 dropped", {7'b0, irq}, 8'h00);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule